// File: doc/BRIEF.md
# Descriptor-Table Playback DMA Sequencer

This block is the address and position engine of one audio playback stream. The host memory holds a table of period descriptors. Each descriptor is 8 bytes: a 32-bit buffer address at offset 0, then a 32-bit word whose upper half is the period length in bytes. The sequencer reads the descriptor of the current list entry and issues 64-byte sample-fetch requests across that period. At the end of the period it moves to the next entry. After the last entry it returns to entry 0.

While it walks the table the sequencer reports five kinds of event: half period, full period, half buffer, full buffer and end of audio. Each event sets a sticky status bit. An interrupt output is raised when a set status bit is also enabled in the mask. An optional stop position ends playback at a given byte offset. A level start input begins and ends the stream.

The memory side is a single-request port. The block holds a request and its address until a one-cycle response strobe arrives. For a descriptor request, that strobe carries the descriptor word.

Top module: `pbk_dma_seq`

## Requirements
- R1: On a rising edge of start while idle, the block requests the word at table base + 8*index (buffer address) with mem_desc high. It then requests base + 8*index + 4, whose bits [31:16] give the period length in bytes.
- R2: Sample requests go to buffer address + period pointer with mem_desc low. Each answered sample request advances the period pointer by 64.
- R3: When the advanced pointer reaches or passes the period length, the period pointer returns to 0, the list pointer moves to the next entry and that entry's descriptor is fetched.
- R4: The table length in bytes minus 8 sits in list_size starting at bit 16 (8 entries gives 0x00380000). The last index is that value divided by 8. Leaving the last entry wraps the list pointer to 0 and sets the full-buffer status bit 12.
- R5: The half-period status bit 0 is set by the answered burst that moves the pointer from below half the period length to at or above it. The full-period bit 4 is set at the end of the period, never before.
- R6: The half-buffer status bit 8 is set at the end of the period whose index is (N/2)-1, where N is the number of entries (integer division).
- R7: When end_cfg bit 16 is 1 and an answered burst moves the pointer to exactly end_cfg[15:0], fetching stops. The end-of-audio status bit 24 is set and mem_req drops.
- R8: Status bits are sticky. A 1 in status_clr clears the matching bit, but an event in the same cycle keeps it set. irq is high exactly when some status bit is 1 and its int_mask bit is 1.
- R9: A restart always begins at entry 0 with the period pointer at 0. With start low, the sequencer finishes the outstanding burst and then goes idle. A new rising edge of start is needed to run again.
- R10: An unanswered request keeps mem_req high and mem_addr unchanged in the next cycle.
- R11: After reset, mem_req, irq, status, list_ptr and period_ptr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run level; a rising edge restarts at entry 0 |
| list_base | input | 32 | Byte address of descriptor table |
| list_size | input | 32 | Table length in bytes minus 8, shifted left by 16 |
| end_cfg | input | 32 | Stop position [15:0], stop enable [16] |
| int_mask | input | 32 | Interrupt enable, same layout as status |
| status_clr | input | 32 | Write-1-to-clear pulses for status |
| mem_req | output | 1 | Memory request valid |
| mem_desc | output | 1 | 1 = descriptor read, 0 = sample burst |
| mem_addr | output | 32 | Request byte address |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_data | input | 32 | Response word for descriptor reads |
| list_ptr | output | 6 | Index of the period now playing |
| period_ptr | output | 16 | Byte position inside the current period |
| status | output | 32 | Sticky event bits 0, 4, 8, 12, 24 |
| irq | output | 1 | Masked OR of status |

## Verification
Assertions check several things on every cycle: request hold, the 64-byte pointer step, pointer reset at each full-period and wrap event, idling after end of audio or a dropped start, and an event winning over a clear. Some behaviours show only in the bench scenarios, where a behavioural reference model is compared against the outputs every cycle. These are the exact descriptor and sample addresses, the half-period crossing for odd and short period lengths, the half-buffer index for 2-, 4- and 8-entry tables, and the stop position.

// File: rtl/pbk_dma_pkg.sv
package pbk_dma_pkg;
   typedef enum logic [1:0] {S_IDLE, S_DADDR, S_DSIZE, S_FETCH} seq_state_e;

   localparam int EV_NUM    = 5;
   localparam int EV_HALF_P = 0;
   localparam int EV_FULL_P = 4;
   localparam int EV_HALF_B = 8;
   localparam int EV_FULL_B = 12;
   localparam int EV_EOA    = 24;

   function automatic int ev_bit(input int k);
      case (k)
         0:       return EV_HALF_P;
         1:       return EV_FULL_P;
         2:       return EV_HALF_B;
         3:       return EV_FULL_B;
         default: return EV_EOA;
      endcase
   endfunction
endpackage

// File: rtl/pbk_dma_fsm.sv
module pbk_dma_fsm
   import pbk_dma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       rsp_valid,
   input  logic       period_end,
   input  logic       stop_hit,
   output seq_state_e state,
   output logic       restart,
   output logic       burst_done
);
   logic start_q;

   assign restart    = (state == S_IDLE) && start && !start_q;
   assign burst_done = (state == S_FETCH) && rsp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         start_q <= 1'b0;
      end else begin
         start_q <= start;
         case (state)
            S_IDLE:  if (restart) state <= S_DADDR;
            S_DADDR: if (rsp_valid) state <= S_DSIZE;
            S_DSIZE: if (rsp_valid) state <= S_FETCH;
            S_FETCH: begin
               if (rsp_valid) begin
                  if (stop_hit || !start) state <= S_IDLE;
                  else if (period_end)    state <= S_DADDR;
                  else                    state <= S_FETCH;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R9: dropping start ends the run once the outstanding burst is answered
   p_halt_on_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_done && !start) |=> (state == S_IDLE));

   // R7: a stop hit leaves the sequencer idle
   p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_done && stop_hit) |=> (state == S_IDLE));
endmodule

// File: rtl/pbk_dma_pos.sv
module pbk_dma_pos
   import pbk_dma_pkg::*;
#(
   parameter int AW          = 32,
   parameter int PTR_W       = 16,
   parameter int IDX_W       = 6,
   parameter int BURST_BYTES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_state_e       state,
   input  logic             restart,
   input  logic             rsp_valid,
   input  logic [31:0]      rsp_data,
   input  logic [AW-1:0]    list_base,
   input  logic [IDX_W-1:0] last_idx,
   output logic [AW-1:0]    mem_addr,
   output logic [IDX_W-1:0] idx,
   output logic [PTR_W-1:0] pptr,
   output logic [PTR_W:0]   nxt_ptr,
   output logic             period_end,
   output logic             half_cross,
   output logic             at_half_idx,
   output logic             at_last_idx
);
   localparam int ENT_SHIFT = 3;

   logic [AW-1:0]    buf_addr;
   logic [PTR_W-1:0] psize;
   logic [PTR_W:0]   half_len;
   logic [IDX_W:0]   n_ent;
   logic [IDX_W-1:0] half_idx;
   logic [AW-1:0]    ent_off;

   generate
      if (BURST_BYTES < 1 || (BURST_BYTES & (BURST_BYTES - 1)) != 0) begin : g_bad_burst
         $error("BURST_BYTES must be a power of two");
      end
      if (PTR_W > 16 || PTR_W < 8) begin : g_bad_ptr
         $error("PTR_W must be 8..16 to fit the length half-word");
      end
   endgenerate

   assign nxt_ptr     = {1'b0, pptr} + (PTR_W+1)'(BURST_BYTES);
   assign half_len    = {1'b0, psize} >> 1;
   assign period_end  = nxt_ptr >= {1'b0, psize};
   assign half_cross  = ({1'b0, pptr} < half_len) && (nxt_ptr >= half_len);
   assign n_ent       = {1'b0, last_idx} + 1'b1;
   assign half_idx    = IDX_W'(n_ent >> 1) - 1'b1;
   assign at_half_idx = (idx == half_idx);
   assign at_last_idx = (idx == last_idx);
   assign ent_off     = AW'({idx, {ENT_SHIFT{1'b0}}});

   always_comb begin
      case (state)
         S_DADDR: mem_addr = list_base + ent_off;
         S_DSIZE: mem_addr = list_base + ent_off + AW'(4);
         S_FETCH: mem_addr = buf_addr + AW'(pptr);
         default: mem_addr = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx      <= '0;
         pptr     <= '0;
         buf_addr <= '0;
         psize    <= '0;
      end else if (restart) begin
         idx  <= '0;
         pptr <= '0;
      end else if (rsp_valid) begin
         case (state)
            S_DADDR: buf_addr <= AW'(rsp_data);
            S_DSIZE: psize    <= rsp_data[16 +: PTR_W];
            S_FETCH: begin
               if (period_end) begin
                  pptr <= '0;
                  idx  <= at_last_idx ? '0 : idx + 1'b1;
               end else begin
                  pptr <= nxt_ptr[PTR_W-1:0];
               end
            end
            default: ;
         endcase
      end
   end

   // R2: an answered burst inside a period steps the pointer by one burst
   p_burst_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_FETCH && rsp_valid && !period_end && !restart)
      |=> (pptr == $past(pptr) + PTR_W'(BURST_BYTES)));

   // R9: a restart lands on entry 0 at offset 0
   p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (idx == '0 && pptr == '0));
endmodule

// File: rtl/pbk_dma_evt.sv
module pbk_dma_evt
   import pbk_dma_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] ev_set,
   input  logic [31:0] ev_clr,
   input  logic [31:0] mask,
   output logic [31:0] status,
   output logic        irq
);
   genvar k;
   generate
      for (k = 0; k < 32; k++) begin : g_bit
         localparam bit USED = (k == EV_HALF_P) || (k == EV_FULL_P) || (k == EV_HALF_B) ||
                               (k == EV_FULL_B) || (k == EV_EOA);
         if (USED) begin : g_flop
            always_ff @(posedge clk) begin
               if (!rst_n) status[k] <= 1'b0;
               else        status[k] <= (status[k] & ~ev_clr[k]) | ev_set[k];
            end
         end else begin : g_zero
            assign status[k] = 1'b0;
         end
      end

      for (k = 0; k < EV_NUM; k++) begin : g_chk
         localparam int B = ev_bit(k);
         // R8: an event in the same cycle as a clear keeps the bit set
         p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ev_set[B] |=> status[B]);
      end
   endgenerate

   assign irq = |(status & mask);
endmodule

// File: rtl/pbk_dma_seq.sv
module pbk_dma_seq
   import pbk_dma_pkg::*;
#(
   parameter int AW          = 32,
   parameter int PTR_W       = 16,
   parameter int IDX_W       = 6,
   parameter int BURST_BYTES = 64,
   parameter int LEN_LSB     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    list_base,
   input  logic [31:0]      list_size,
   input  logic [31:0]      end_cfg,
   input  logic [31:0]      int_mask,
   input  logic [31:0]      status_clr,
   output logic             mem_req,
   output logic             mem_desc,
   output logic [AW-1:0]    mem_addr,
   input  logic             rsp_valid,
   input  logic [31:0]      rsp_data,
   output logic [IDX_W-1:0] list_ptr,
   output logic [PTR_W-1:0] period_ptr,
   output logic [31:0]      status,
   output logic             irq
);
   localparam int ENT_SHIFT = 3;
   localparam int IDX_LSB   = LEN_LSB + ENT_SHIFT;

   generate
      if (IDX_LSB + IDX_W > 32) begin : g_bad_len
         $error("list length field does not fit in list_size");
      end
   endgenerate

   seq_state_e       state;
   logic             restart, burst_done;
   logic [PTR_W:0]   nxt_ptr;
   logic             period_end, half_cross, at_half_idx, at_last_idx;
   logic             stop_hit;
   logic [IDX_W-1:0] last_idx;
   logic [31:0]      ev_set;
   logic             unused_cfg;

   assign last_idx   = list_size[IDX_LSB +: IDX_W];
   assign stop_hit   = end_cfg[16] && (nxt_ptr == {1'b0, PTR_W'(end_cfg[15:0])});
   assign unused_cfg = ^{list_size, end_cfg[31:17], end_cfg[15:0]};

   pbk_dma_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .rsp_valid  (rsp_valid),
      .period_end (period_end),
      .stop_hit   (stop_hit),
      .state      (state),
      .restart    (restart),
      .burst_done (burst_done)
   );

   pbk_dma_pos #(
      .AW          (AW),
      .PTR_W       (PTR_W),
      .IDX_W       (IDX_W),
      .BURST_BYTES (BURST_BYTES)
   ) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .restart     (restart),
      .rsp_valid   (rsp_valid),
      .rsp_data    (rsp_data),
      .list_base   (list_base),
      .last_idx    (last_idx),
      .mem_addr    (mem_addr),
      .idx         (list_ptr),
      .pptr        (period_ptr),
      .nxt_ptr     (nxt_ptr),
      .period_end  (period_end),
      .half_cross  (half_cross),
      .at_half_idx (at_half_idx),
      .at_last_idx (at_last_idx)
   );

   always_comb begin
      ev_set = '0;
      ev_set[EV_HALF_P] = burst_done && half_cross;
      ev_set[EV_FULL_P] = burst_done && period_end;
      ev_set[EV_HALF_B] = burst_done && period_end && at_half_idx;
      ev_set[EV_FULL_B] = burst_done && period_end && at_last_idx;
      ev_set[EV_EOA]    = burst_done && stop_hit;
   end

   pbk_dma_evt u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_set (ev_set),
      .ev_clr (status_clr),
      .mask   (int_mask),
      .status (status),
      .irq    (irq)
   );

   assign mem_req  = (state != S_IDLE);
   assign mem_desc = (state == S_DADDR) || (state == S_DSIZE);

   // R10: an unanswered request is held with the same address
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !rsp_valid) |=> (mem_req && $stable(mem_addr)));

   // R4: the full-buffer event coincides with the list pointer wrapping to 0
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[EV_FULL_B]) |-> (list_ptr == '0));

   // R3: the full-period event appears only with the pointer back at 0
   p_period_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[EV_FULL_P]) |-> (period_ptr == '0));

   // R7: end of audio leaves no request pending
   p_eoa_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[EV_EOA]) |-> !mem_req);
endmodule

// File: tb/pbk_dma_seq_tb_top.sv
`timescale 1ns/1ps
module pbk_dma_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] list_base = 32'h100;
   logic [31:0] list_size = 32'h0;
   logic [31:0] end_cfg = 32'h0;
   logic [31:0] int_mask = 32'h0;
   logic [31:0] status_clr = 32'h0;
   logic        mem_req, mem_desc, irq;
   logic [31:0] mem_addr, status;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_data = 32'h0;
   logic [5:0]  list_ptr;
   logic [15:0] period_ptr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pbk_dma_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
      .list_size(list_size), .end_cfg(end_cfg), .int_mask(int_mask),
      .status_clr(status_clr), .mem_req(mem_req), .mem_desc(mem_desc),
      .mem_addr(mem_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .list_ptr(list_ptr), .period_ptr(period_ptr), .status(status), .irq(irq)
   );

   int size_tab [8] = '{128, 192, 64, 256, 320, 64, 128, 192};

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      int off;
      off = int'(a) - int'(list_base);
      if (off >= 0 && off < 64) begin
         if (a[2] == 1'b0) return 32'h4000_0000 + 32'(off / 8) * 32'h1_0000;
         else              return 32'(size_tab[off / 8]) << 16;
      end
      return 32'h0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model, advanced at each rising edge
   int          m_st = 0;
   int          m_idx = 0, m_pptr = 0, m_psize = 0;
   logic [31:0] m_buf = 0, m_status = 0;
   bit          m_sq = 0;

   always @(posedge clk) begin
      logic [31:0] ev;
      int nxt, last, half;
      bit pend, stop;
      if (!rst_n) begin
         m_st = 0; m_idx = 0; m_pptr = 0; m_psize = 0; m_buf = 0; m_status = 0; m_sq = 0;
      end else begin
         ev = 0;
         case (m_st)
            0: if (start && !m_sq) begin m_idx = 0; m_pptr = 0; m_st = 1; end
            1: if (rsp_valid) begin m_buf = rsp_data; m_st = 2; end
            2: if (rsp_valid) begin m_psize = int'(rsp_data >> 16); m_st = 3; end
            default: if (rsp_valid) begin
               nxt  = m_pptr + 64;
               last = int'((list_size >> 19) & 32'h3f);
               half = ((last + 1) / 2) - 1;
               if (m_pptr < m_psize / 2 && nxt >= m_psize / 2) ev[0] = 1'b1;
               pend = (nxt >= m_psize);
               stop = end_cfg[16] && (nxt == int'(end_cfg[15:0]));
               if (pend) begin
                  ev[4] = 1'b1;
                  if (m_idx == half) ev[8] = 1'b1;
                  if (m_idx == last) ev[12] = 1'b1;
                  m_idx  = (m_idx == last) ? 0 : m_idx + 1;
                  m_pptr = 0;
               end else m_pptr = nxt;
               if (stop) begin ev[24] = 1'b1; m_st = 0; end
               else if (!start) m_st = 0;
               else m_st = pend ? 1 : 3;
            end
         endcase
         m_status = (m_status & ~status_clr) | ev;
         m_sq = start;
      end
   end

   // compare and memory responder, away from the active edge
   int wcnt = 0, nresp = 0;
   always @(negedge clk) begin
      logic [31:0] ea;
      if (rst_n && !done) begin
         chk(mem_req == (m_st != 0), "R9/R10 mem_req", 32'(mem_req), 32'(m_st != 0));
         if (m_st != 0) begin
            ea = (m_st == 1) ? list_base + 32'(m_idx * 8) :
                 (m_st == 2) ? list_base + 32'(m_idx * 8 + 4) : m_buf + 32'(m_pptr);
            chk(mem_addr == ea, "R1/R2 mem_addr", mem_addr, ea);
            chk(mem_desc == (m_st != 3), "R1 mem_desc", 32'(mem_desc), 32'(m_st != 3));
         end
         chk(period_ptr == 16'(m_pptr), "R2/R3 period_ptr", 32'(period_ptr), 32'(m_pptr));
         chk(list_ptr == 6'(m_idx), "R3/R4 list_ptr", 32'(list_ptr), 32'(m_idx));
         chk(status == m_status, "R5/R6/R7/R8 status", status, m_status);
         chk(irq == |(m_status & int_mask), "R8 irq", 32'(irq), 32'(|(m_status & int_mask)));
      end
      if (rsp_valid) rsp_valid = 1'b0;
      else if (mem_req) begin
         wcnt++;
         if (wcnt >= 1 + (nresp % 3)) begin
            rsp_valid = 1'b1;
            rsp_data  = mem_word(mem_addr);
            wcnt = 0;
            nresp++;
         end
      end else wcnt = 0;
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_pulse(input logic [31:0] v);
      @(negedge clk); status_clr = v;
      @(negedge clk); status_clr = 32'h0;
   endtask

   initial begin
      int_mask = 32'h0100_1111;
      cyc(4);
      // R11: reset state
      chk(!mem_req && !irq && status == 0 && list_ptr == 0 && period_ptr == 0,
          "R11 reset", status, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      cyc(2);

      // four-entry table: R1..R6, R8
      list_size = 32'h0018_0000;
      start = 1'b1;
      cyc(120);
      clear_pulse(32'h0000_0011);
      cyc(200);
      chk(status[12] == 1'b1, "R4 full buffer seen", status, 32'h1000);
      chk(status[8] == 1'b1, "R6 half buffer seen", status, 32'h100);
      clear_pulse(32'hffff_ffff);

      // drop start: R9
      start = 1'b0;
      cyc(12);
      chk(mem_req == 1'b0, "R9 halted after drop", 32'(mem_req), 32'h0);
      cyc(5);
      chk(mem_req == 1'b0, "R9 stays idle", 32'(mem_req), 32'h0);

      // eight-entry table: R4, R6
      list_size = 32'h0038_0000;
      start = 1'b1;
      cyc(600);
      chk(status[12] == 1'b1, "R4 eight-entry wrap", status, 32'h1000);
      start = 1'b0;
      cyc(20);

      // stop position: R7
      list_size = 32'h0018_0000;
      end_cfg = 32'h0001_0080;
      clear_pulse(32'hffff_ffff);
      start = 1'b1;
      cyc(40);
      chk(status[24] == 1'b1, "R7 end of audio", status, 32'h0100_0000);
      chk(mem_req == 1'b0, "R7 stopped", 32'(mem_req), 32'h0);
      chk(irq == 1'b1, "R8 irq from end of audio", 32'(irq), 32'h1);
      start = 1'b0;
      end_cfg = 32'h0;
      cyc(4);

      // two-entry table, irq masked off: R6, R8
      int_mask = 32'h0;
      list_size = 32'h0008_0000;
      start = 1'b1;
      cyc(150);
      chk(irq == 1'b0, "R8 masked irq", 32'(irq), 32'h0);
      start = 1'b0;
      cyc(20);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      done = 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule